// File: doc/BRIEF.md
# Promotable Priority Interrupt Arbiter

This block arbitrates among eight maskable interrupt sources: timer overflow, pulse accumulator overflow, pulse accumulator input edge, serial peripheral transfer done, serial communication, external IRQ pin, real-time tick and input capture 1. Without any programming, the sources follow a fixed ranking with IRQ on top. A 4-bit promote register lets software lift any single source above all the others. The rest keep their fixed relative ranking.

The promote register takes a write only while the global interrupt mask input is set. Software therefore has to mask interrupts before it changes priorities. The register reads back exactly the value that was written. Codes that name no source act like the IRQ code. The winner ID follows the requests combinationally. The pending output also needs the mask to be clear. Vector fetch, stacking and non-maskable sources sit outside the block.

Source IDs, which are also the bit positions in `req_i`: 0 timer overflow, 1 pulse accumulator overflow, 2 pulse accumulator edge, 3 serial peripheral done, 4 serial communication, 5 IRQ pin, 6 real-time tick, 7 input capture 1.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset, `sel_o` reads 4'b0101 and IRQ (ID 5) is the highest-priority source.
- R2: A write with `sel_we_i`=1 and `mask_i`=1 loads `sel_wdata_i` into the promote register, and `sel_o` shows it after the next rising clock edge.
- R3: A write with `mask_i`=0 is ignored and `sel_o` keeps its value.
- R4: `sel_o` returns the written code unchanged, reserved codes included.
- R5: With the default promotion, the ranking from highest to lowest is ID 5, 6, 7, 0, 1, 2, 3, 4.
- R6: Promote codes map to sources as follows: 0000→ID0, 0001→ID1, 0010→ID2, 0011→ID3, 0100→ID4, 0110→ID5, 0111→ID6, 1000→ID7. A promoted source that is requesting wins over every other request, and the rest keep the R5 order.
- R7: Codes 0101 and 1001 through 1111 behave exactly like 0110, so IRQ is promoted.
- R8: `pend_o` is 1 exactly when `mask_i`=0 and at least one `req_i` bit is set.
- R9: With no request active, `win_id_o` is 0.
- R10: `win_id_o` follows `req_i` in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Request vector, bit n is source ID n |
| mask_i | input | 1 | Global interrupt mask, 1 = masked |
| sel_we_i | input | 1 | Promote register write strobe |
| sel_wdata_i | input | 4 | Promote register write data |
| sel_o | output | 4 | Promote register readback |
| pend_o | output | 1 | Interrupt pending |
| win_id_o | output | 3 | ID of the winning source |

## Verification
The bench builds the block with its default parameters: eight sources, a 4-bit promote code and IRQ at ID 5. With these values all sixteen promote codes can be reached, including the seven codes above the last source and the in-range reserved code. Each code is checked against full and partial request patterns. The default ranking is walked by dropping the current winner one source at a time. Masked and unmasked writes are interleaved, so the readback shows whether a write gated off by the mask left its mark.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NUM_SRC = 8;
  localparam int SEL_W   = 4;
  localparam int ID_W    = $clog2(NUM_SRC);
  localparam int IRQ_ID  = 5;

  // promote code -> source id; the code equal to irq_id is a reserved alias
  function automatic logic [ID_W-1:0] code_to_id(input logic [SEL_W-1:0] code,
                                                 input int irq_id, input int num_src);
    int c;
    c = int'(code);
    if (c < irq_id)        return ID_W'(c);
    else if (c == irq_id)  return ID_W'(irq_id);
    else if (c <= num_src) return ID_W'(c - 1);
    else                   return ID_W'(irq_id);
  endfunction

  // default ranking: irq first, then wrap around the id space
  function automatic logic [ID_W-1:0] rank_src(input int rank, input int irq_id,
                                               input int num_src);
    return ID_W'((rank + irq_id) % num_src);
  endfunction
endpackage

// File: rtl/prio_sel_reg.sv
module prio_sel_reg #(
  parameter int SEL_W    = 4,
  parameter int RST_CODE = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             mask_i,
  input  logic [SEL_W-1:0] wdata_i,
  output logic [SEL_W-1:0] sel_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              sel_q_o <= SEL_W'(RST_CODE);
    else if (we_i && mask_i)  sel_q_o <= wdata_i;
  end
endmodule

// File: rtl/prio_sel_decode.sv
module prio_sel_decode
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = 4,
  parameter int ID_W    = $clog2(NUM_SRC),
  parameter int IRQ_ID  = 5
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [ID_W-1:0]  promo_id_o
);
  always_comb promo_id_o = code_to_id(sel_i, IRQ_ID, NUM_SRC);
endmodule

// File: rtl/prio_pick.sv
module prio_pick
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = $clog2(NUM_SRC),
  parameter int IRQ_ID  = 5
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [ID_W-1:0]    promo_id_i,
  output logic               any_o,
  output logic [ID_W-1:0]    win_id_o
);
  logic [NUM_SRC-1:0] req_ord;
  logic [ID_W-1:0]    src_ord [NUM_SRC];
  logic [ID_W-1:0]    chain_id;

  for (genvar r = 0; r < NUM_SRC; r++) begin : g_rank
    localparam logic [ID_W-1:0] SRC = rank_src(r, IRQ_ID, NUM_SRC);
    assign src_ord[r] = SRC;
    assign req_ord[r] = req_i[SRC];
  end

  // fixed chain: scan from lowest rank so highest active overwrites
  always_comb begin
    chain_id = '0;
    for (int r = NUM_SRC - 1; r >= 0; r--) begin
      if (req_ord[r]) chain_id = src_ord[r];
    end
  end

  always_comb begin
    any_o    = |req_i;
    win_id_o = req_i[promo_id_i] ? promo_id_i : chain_id;
  end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC  = prio_irq_pkg::NUM_SRC,
  parameter int SEL_W    = prio_irq_pkg::SEL_W,
  parameter int IRQ_ID   = prio_irq_pkg::IRQ_ID,
  localparam int ID_W    = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               mask_i,
  input  logic               sel_we_i,
  input  logic [SEL_W-1:0]   sel_wdata_i,
  output logic [SEL_W-1:0]   sel_o,
  output logic               pend_o,
  output logic [ID_W-1:0]    win_id_o
);
  logic [ID_W-1:0] promo_id;
  logic            any_req;

  prio_sel_reg #(.SEL_W(SEL_W), .RST_CODE(IRQ_ID)) u_sel_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (sel_we_i),
    .mask_i  (mask_i),
    .wdata_i (sel_wdata_i),
    .sel_q_o (sel_o)
  );

  prio_sel_decode #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .ID_W(ID_W), .IRQ_ID(IRQ_ID)) u_dec (
    .sel_i      (sel_o),
    .promo_id_o (promo_id)
  );

  prio_pick #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .IRQ_ID(IRQ_ID)) u_pick (
    .req_i      (req_i),
    .promo_id_i (promo_id),
    .any_o      (any_req),
    .win_id_o   (win_id_o)
  );

  assign pend_o = any_req & ~mask_i;
endmodule

// File: rtl/prio_irq_arbiter_chk.sv
module prio_irq_arbiter_chk #(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = 4,
  parameter int ID_W    = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] req_i,
  input logic               mask_i,
  input logic               sel_we_i,
  input logic [SEL_W-1:0]   sel_wdata_i,
  input logic [SEL_W-1:0]   sel_o,
  input logic               pend_o,
  input logic [ID_W-1:0]    win_id_o
);
  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_we_i && mask_i) |=> (sel_o == $past(sel_wdata_i)));

  p_masked_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_we_i && !mask_i) |=> $stable(sel_o));

  p_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we_i |=> $stable(sel_o));

  p_pend_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> (!mask_i && (req_i != '0)));

  p_pend_open_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mask_i && (req_i != '0)) |-> pend_o);

  p_winner_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> req_i[win_id_o]);

  p_idle_id_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |-> (win_id_o == '0));
endmodule

bind prio_irq_arbiter prio_irq_arbiter_chk #(
  .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .ID_W(ID_W)
) u_chk (.*);

// File: tb/prio_irq_arbiter_bench.sv
module prio_irq_arbiter_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic       pend;
    logic [2:0] id;
    logic [3:0] sel;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       mask = 1'b1;
  logic       we = 1'b0;
  logic [3:0] wdata = '0;
  logic [3:0] sel;
  logic       pend;
  logic [2:0] win_id;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;
  exp_t sb_q[$];
  event chk_ev;
  logic [3:0] m_sel = 4'b0101;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_arbiter u_prio_irq_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mask_i(mask),
    .sel_we_i(we), .sel_wdata_i(wdata), .sel_o(sel),
    .pend_o(pend), .win_id_o(win_id)
  );

  function automatic logic [2:0] promo_of(input logic [3:0] c);
    case (c)
      4'd0: return 3'd0;  4'd1: return 3'd1;  4'd2: return 3'd2;
      4'd3: return 3'd3;  4'd4: return 3'd4;  4'd6: return 3'd5;
      4'd7: return 3'd6;  4'd8: return 3'd7;
      default: return 3'd5;
    endcase
  endfunction

  function automatic logic [2:0] model_win(input logic [3:0] c, input logic [7:0] r);
    int order [8] = '{5, 6, 7, 0, 1, 2, 3, 4};
    logic [2:0] p;
    p = promo_of(c);
    if (r[p]) return p;
    foreach (order[i]) if (r[order[i]]) return 3'(order[i]);
    return 3'd0;
  endfunction

  // driver: apply at negedge; writes settle after the following posedge
  task automatic step(input logic [7:0] r, input logic m, input logic w,
                      input logic [3:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    req = r; mask = m; we = w; wdata = d;
    if (w) begin
      @(posedge clk);
      if (m) m_sel = d;
      @(negedge clk);
      we = 1'b0;
    end
    #1;
    e.pend = !m && (r != 0);
    e.id   = model_win(m_sel, r);
    e.sel  = m_sel;
    e.tag  = tag;
    sb_q.push_back(e);
    ->chk_ev;
  endtask

  // monitor: pop and compare
  always begin
    exp_t e;
    @(chk_ev);
    while (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      n_cmp++;
      if (pend !== e.pend || win_id !== e.id || sel !== e.sel) begin
        n_bad++;
        $display("FAIL %s: pend/id/sel got %b/%0d/%b exp %b/%0d/%b",
                 e.tag, pend, win_id, sel, e.pend, e.id, e.sel);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset code and irq on top
    step(8'hFF, 1'b1, 1'b0, 4'h0, "R1 reset");
    step(8'hFF, 1'b0, 1'b0, 4'h0, "R1 irq top");

    // R5: walk default order by dropping current winner
    begin
      logic [7:0] r;
      r = 8'hFF;
      for (int k = 0; k < 8; k++) begin
        step(r, 1'b0, 1'b0, 4'h0, "R5 default order");
        r[model_win(m_sel, r)] = 1'b0;
      end
    end

    // R9: idle id
    step(8'h00, 1'b0, 1'b0, 4'h0, "R9 idle");

    // R2/R6: promote each in-range code, masked write
    for (int c = 0; c < 9; c++) begin
      step(8'h00, 1'b1, 1'b1, 4'(c), "R2 masked write");
      step(8'hFF, 1'b0, 1'b0, 4'h0, "R6 promoted all req");
      step(8'hFF & ~(8'h1 << promo_of(4'(c))), 1'b0, 1'b0, 4'h0, "R6 fallback order");
      step(8'h01 << promo_of(4'(c)) | 8'h10, 1'b0, 1'b0, 4'h0, "R6 pair");
    end

    // R7/R4: reserved codes
    for (int c = 9; c < 16; c++) begin
      step(8'h00, 1'b1, 1'b1, 4'(c), "R4 reserved readback");
      step(8'hDF, 1'b0, 1'b0, 4'h0, "R7 reserved no irq");
      step(8'h21, 1'b0, 1'b0, 4'h0, "R7 reserved irq");
    end
    step(8'h00, 1'b1, 1'b1, 4'h5, "R4 code 0101 readback");
    step(8'h61, 1'b0, 1'b0, 4'h0, "R7 code 0101");

    // R3: unmasked writes ignored
    step(8'h00, 1'b1, 1'b1, 4'h3, "R2 set spi");
    step(8'h00, 1'b0, 1'b1, 4'h7, "R3 ignored write");
    step(8'hFF, 1'b0, 1'b0, 4'h0, "R3 spi still promoted");
    step(8'h00, 1'b0, 1'b1, 4'h0, "R3 ignored write 2");

    // R8: pending gated by mask
    step(8'h40, 1'b1, 1'b0, 4'h0, "R8 masked");
    step(8'h40, 1'b0, 1'b0, 4'h0, "R8 open");
    step(8'h00, 1'b0, 1'b0, 4'h0, "R8 no req");

    // R10: requests change between edges
    @(negedge clk);
    req = 8'h80; mask = 1'b0;
    #1;
    n_cmp++;
    if (win_id !== 3'd7) begin
      n_bad++;
      $display("FAIL R10 comb: got %0d exp 7", win_id);
    end
    req = 8'h88;
    #1;
    n_cmp++;
    if (win_id !== 3'd3) begin
      n_bad++;
      $display("FAIL R10 comb: got %0d exp 3", win_id);
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule